// File: doc/BRIEF.md
# Interrupt controller register-port decoder

This block sits in front of an eight-input programmable interrupt controller and turns byte writes on two register ports into the controller's configuration state and command strobes. One port takes commands and the other takes data; a single address bit selects between them. A command write with bit 4 set starts the initialization sequence. The data writes that follow are taken, in turn, as the vector base, the cascade word and the mode word. Once the sequence ends, data writes load the interrupt mask.

Command writes outside initialization are decoded into end-of-interrupt strobes (specific, with a level, or nonspecific), special-mask-mode set and clear strobes, and a read-register select. Mode bits that the controller does not implement raise a one-cycle error pulse instead of taking effect. Reads return the mask on the data port, and on the command port either the in-service or the request register. Both of those registers are held by the priority logic outside this block and arrive here as inputs.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask reads 0xFF, the vector base is 0x00, the sequence index is 0, the command-port read selects the request register, and every strobe is low.
- R2: A data-port write (address 1) while the sequence index is 0 loads the mask from the byte and pulses mask_ld in the cycle after the write. A data-port read returns the mask one cycle after rd_en.
- R3: A command-port write (address 0) with bit 4 set sets the sequence index to 1 from any index. If bit 2 or bit 3 of that byte is set, err pulses for one cycle, and the sequence still restarts.
- R4: A data-port write at sequence index 1 loads the vector base as the byte ANDed with 0xF8 and pulses vbase_ld.
- R5: The sequence index takes the values 0 (idle), 1 (vector word), 2 (cascade word) and 3 (mode word). Bit 1 of the first word set means single mode, and bit 0 set means a mode word follows. After the vector word the index goes to 2 if cascaded, to 3 if single with a mode word, and to 0 otherwise. After the cascade word it goes to 3 if a mode word follows, otherwise to 0. After the mode word it goes to 0. Data writes at a nonzero index leave the mask unchanged.
- R6: A command write with bits 4 and 3 clear and bit 5 set is an end of interrupt. With bit 6 set it pulses eoi_spec, and eoi_lvl carries byte[2:0]. With bit 6 clear it pulses eoi_nonspec.
- R7: An end-of-interrupt command with bit 7 (rotation) set pulses err and pulses neither eoi_spec nor eoi_nonspec.
- R8: A command write with bit 4 clear and bit 3 set that has bit 6 set pulses smm_set if bit 5 is 1, and smm_clr if bit 5 is 0. With bit 6 clear it pulses neither.
- R9: In that same command form, bit 1 set makes bit 0 the read select (1 = in-service, 0 = request). With bit 1 clear the select is kept. A command-port read returns the selected input register one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 1 | Port select: 0 command, 1 data |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Port select for the read |
| irr_in | input | 8 | Request register from the priority logic |
| isr_in | input | 8 | In-service register from the priority logic |
| rd_data | output | 8 | Registered read result |
| mask_q | output | 8 | Interrupt mask register |
| mask_ld | output | 1 | Mask loaded pulse |
| vbase_q | output | 8 | Vector base (low three bits zero) |
| vbase_ld | output | 1 | Vector base loaded pulse |
| eoi_spec | output | 1 | Specific end-of-interrupt pulse |
| eoi_nonspec | output | 1 | Nonspecific end-of-interrupt pulse |
| eoi_lvl | output | 3 | Level for the specific end of interrupt |
| smm_set | output | 1 | Special mask mode on pulse |
| smm_clr | output | 1 | Special mask mode off pulse |
| sel_isr | output | 1 | Command-port read select (1 = in-service) |
| err | output | 1 | Unsupported mode bit pulse |
| seq_idx | output | 2 | Initialization sequence index |

## Verification
The bench builds the block with its default byte width of 8, which gives eight levels and a three-bit level field. At that width every control-bit position in the command bytes can be reached. All four routes through the initialization sequence are driven: cascaded with and without a mode word, and single with and without one. Restarts in mid-sequence, the unsupported-bit errors and both read selects are exercised against the request and in-service inputs.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_VBASE = 2'd1,
    SEQ_CASC  = 2'd2,
    SEQ_MODE  = 2'd3
  } seq_e;

  typedef struct packed {
    logic start;
    logic eoi_s;
    logic eoi_n;
    logic smm_s;
    logic smm_c;
    logic sel_ld;
    logic sel_val;
    logic err;
  } cmd_dec_t;
endpackage

// File: rtl/irq_seq_tracker.sv
module irq_seq_tracker
  import irq_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic single_in,
  input  logic mode_in,
  input  logic data_wr,
  output logic mask_wr,
  output logic vbase_wr,
  output seq_e seq_q
);
  logic single_q;
  logic mode_q;
  seq_e seq_d;

  always_comb begin
    seq_d = seq_q;
    if (data_wr) begin
      case (seq_q)
        SEQ_VBASE: begin
          if (!single_q)    seq_d = SEQ_CASC;
          else if (mode_q)  seq_d = SEQ_MODE;
          else              seq_d = SEQ_IDLE;
        end
        SEQ_CASC:  seq_d = mode_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE:  seq_d = SEQ_IDLE;
        default:   seq_d = SEQ_IDLE;
      endcase
    end
    if (start) seq_d = SEQ_VBASE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q    <= SEQ_IDLE;
      single_q <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      seq_q <= seq_d;
      if (start) begin
        single_q <= single_in;
        mode_q   <= mode_in;
      end
    end
  end

  assign mask_wr  = data_wr && (seq_q == SEQ_IDLE);
  assign vbase_wr = data_wr && (seq_q == SEQ_VBASE);
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] byte_in,
  output cmd_dec_t          dec
);
  logic is_init;
  logic is_ocw3;
  logic is_ocw2;
  logic eoi_req;

  assign is_init = byte_in[4];
  assign is_ocw3 = !byte_in[4] && byte_in[3];
  assign is_ocw2 = !byte_in[4] && !byte_in[3];
  assign eoi_req = is_ocw2 && byte_in[5];

  always_comb begin
    dec = '0;
    if (cmd_wr) begin
      dec.start   = is_init;
      dec.eoi_s   = eoi_req && !byte_in[7] && byte_in[6];
      dec.eoi_n   = eoi_req && !byte_in[7] && !byte_in[6];
      dec.smm_s   = is_ocw3 && byte_in[6] && byte_in[5];
      dec.smm_c   = is_ocw3 && byte_in[6] && !byte_in[5];
      dec.sel_ld  = is_ocw3 && byte_in[1];
      dec.sel_val = byte_in[0];
      dec.err     = (is_init && (byte_in[2] || byte_in[3])) ||
                    (eoi_req && byte_in[7]);
    end
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_addr,
  input  logic              sel_isr,
  input  logic [DATA_W-1:0] mask_in,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr)      rd_data <= mask_in;
      else if (sel_isr) rd_data <= isr_in;
      else              rd_data <= irr_in;
    end
  end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import irq_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DATA_W),
  localparam int VB_LSB = LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_addr,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] mask_q,
  output logic              mask_ld,
  output logic [DATA_W-1:0] vbase_q,
  output logic              vbase_ld,
  output logic              eoi_spec,
  output logic              eoi_nonspec,
  output logic [LVL_W-1:0]  eoi_lvl,
  output logic              smm_set,
  output logic              smm_clr,
  output logic              sel_isr,
  output logic              err,
  output logic [1:0]        seq_idx
);
  cmd_dec_t dec;
  seq_e     seq_q;
  logic     mask_wr;
  logic     vbase_wr;
  logic     cmd_wr;
  logic     data_wr;

  assign cmd_wr  = wr_en && !wr_addr;
  assign data_wr = wr_en && wr_addr;

  irq_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_wr  (cmd_wr),
    .byte_in (wr_data),
    .dec     (dec)
  );

  irq_seq_tracker u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (dec.start),
    .single_in (wr_data[1]),
    .mode_in   (wr_data[0]),
    .data_wr   (data_wr),
    .mask_wr   (mask_wr),
    .vbase_wr  (vbase_wr),
    .seq_q     (seq_q)
  );

  irq_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .sel_isr (sel_isr),
    .mask_in (mask_q),
    .irr_in  (irr_in),
    .isr_in  (isr_in),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '1;
      vbase_q     <= '0;
      sel_isr     <= 1'b0;
      mask_ld     <= 1'b0;
      vbase_ld    <= 1'b0;
      eoi_spec    <= 1'b0;
      eoi_nonspec <= 1'b0;
      eoi_lvl     <= '0;
      smm_set     <= 1'b0;
      smm_clr     <= 1'b0;
      err         <= 1'b0;
    end else begin
      mask_ld     <= mask_wr;
      vbase_ld    <= vbase_wr;
      eoi_spec    <= dec.eoi_s;
      eoi_nonspec <= dec.eoi_n;
      smm_set     <= dec.smm_s;
      smm_clr     <= dec.smm_c;
      err         <= dec.err;
      if (dec.eoi_s) eoi_lvl <= wr_data[LVL_W-1:0];
      if (mask_wr)   mask_q  <= wr_data;
      if (vbase_wr)  vbase_q <= {wr_data[DATA_W-1:VB_LSB], {VB_LSB{1'b0}}};
      if (dec.sel_ld) sel_isr <= dec.sel_val;
    end
  end

  assign seq_idx = seq_q;
endmodule

// File: rtl/irq_cmd_decoder_chk.sv
module irq_cmd_decoder_chk #(
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] mask_q,
  input logic              mask_ld,
  input logic              vbase_ld,
  input logic              eoi_spec,
  input logic              eoi_nonspec,
  input logic [LVL_W-1:0]  eoi_lvl,
  input logic              smm_set,
  input logic              smm_clr,
  input logic              err,
  input logic [1:0]        seq_idx
);
  AST_MASK_LD_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    mask_ld |-> $past(wr_en && wr_addr && seq_idx == 2'd0)); // R2
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    !mask_ld |-> $stable(mask_q)); // R5
  AST_VBASE_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    vbase_ld |-> $past(seq_idx == 2'd1 && wr_en && wr_addr)); // R4
  AST_START_SEQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data[4]) |=> (seq_idx == 2'd1)); // R3
  AST_EOI_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(eoi_spec && eoi_nonspec)); // R6
  AST_EOI_LVL: assert property (@(posedge clk) disable iff (rst)
    eoi_spec |-> (eoi_lvl == $past(wr_data[LVL_W-1:0]))); // R6
  AST_ERR_NO_EOI: assert property (@(posedge clk) disable iff (rst)
    err |-> !(eoi_spec || eoi_nonspec)); // R7
  AST_SMM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(smm_set && smm_clr)); // R8
endmodule

bind irq_cmd_decoder irq_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mask_q(mask_q), .mask_ld(mask_ld), .vbase_ld(vbase_ld),
  .eoi_spec(eoi_spec), .eoi_nonspec(eoi_nonspec), .eoi_lvl(eoi_lvl),
  .smm_set(smm_set), .smm_clr(smm_clr), .err(err), .seq_idx(seq_idx)
);

// File: tb/irq_cmd_decoder_tb_top.sv
module irq_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] irr_in = 8'h3C;
  logic [7:0] isr_in = 8'h81;
  logic [7:0] rd_data, mask_q, vbase_q;
  logic       mask_ld, vbase_ld, eoi_spec, eoi_nonspec, smm_set, smm_clr, sel_isr, err;
  logic [2:0] eoi_lvl;
  logic [1:0] seq_idx;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .irr_in(irr_in), .isr_in(isr_in),
    .rd_data(rd_data), .mask_q(mask_q), .mask_ld(mask_ld), .vbase_q(vbase_q),
    .vbase_ld(vbase_ld), .eoi_spec(eoi_spec), .eoi_nonspec(eoi_nonspec),
    .eoi_lvl(eoi_lvl), .smm_set(smm_set), .smm_clr(smm_clr), .sel_isr(sel_isr),
    .err(err), .seq_idx(seq_idx)
  );

  // entry: addr, data, lvl[2:0], seq[1:0], mask_ld, vb_ld, eoi_s, eoi_n, smm_s, smm_c, err
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 8'h11, 3'd0, 2'd1, 7'b0000000},  // R3 cascaded + mode word
    {1'b1, 8'h75, 3'd0, 2'd2, 7'b0100000},  // R4 R5
    {1'b1, 8'h04, 3'd0, 2'd3, 7'b0000000},  // R5
    {1'b1, 8'h01, 3'd0, 2'd0, 7'b0000000},  // R5
    {1'b1, 8'hA5, 3'd0, 2'd0, 7'b1000000},  // R2
    {1'b0, 8'h13, 3'd0, 2'd1, 7'b0000000},  // R3 single + mode word
    {1'b1, 8'h0F, 3'd0, 2'd3, 7'b0100000},  // R5 skip cascade word
    {1'b1, 8'h00, 3'd0, 2'd0, 7'b0000000},  // R5
    {1'b0, 8'h12, 3'd0, 2'd1, 7'b0000000},  // R3 single, no mode word
    {1'b1, 8'h20, 3'd0, 2'd0, 7'b0100000},  // R5
    {1'b0, 8'h1C, 3'd0, 2'd1, 7'b0000001},  // R3 unsupported bits
    {1'b1, 8'h48, 3'd0, 2'd2, 7'b0100000},  // R5 cascaded, no mode word
    {1'b1, 8'h00, 3'd0, 2'd0, 7'b0000000},  // R5
    {1'b0, 8'h63, 3'd3, 2'd0, 7'b0010000},  // R6 specific
    {1'b0, 8'h20, 3'd3, 2'd0, 7'b0001000},  // R6 nonspecific
    {1'b0, 8'hA0, 3'd3, 2'd0, 7'b0000001},  // R7
    {1'b0, 8'hE7, 3'd3, 2'd0, 7'b0000001},  // R7
    {1'b0, 8'h68, 3'd3, 2'd0, 7'b0000100},  // R8 set
    {1'b0, 8'h48, 3'd3, 2'd0, 7'b0000010},  // R8 clear
    {1'b0, 8'h08, 3'd3, 2'd0, 7'b0000000},  // R8 no effect
    {1'b0, 8'h00, 3'd3, 2'd0, 7'b0000000}   // R6 no EOI
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mask", mask_q, 8'hFF);
    check("R1 vbase", vbase_q, 8'h00);
    check("R1 seq", seq_idx, 2'd0);
    check("R1 sel", sel_isr, 1'b0);
    check("R1 strobes", {mask_ld, vbase_ld, eoi_spec, eoi_nonspec, smm_set, smm_clr, err}, 7'b0);

    for (int i = 0; i < NVEC; i++) begin
      do_wr(VEC[i][20], VEC[i][19:12]);
      check($sformatf("vec%0d strobes R2 R6 R7 R8", i),
            {mask_ld, vbase_ld, eoi_spec, eoi_nonspec, smm_set, smm_clr, err}, VEC[i][6:0]);
      check($sformatf("vec%0d seq R5", i), seq_idx, VEC[i][8:7]);
      if (VEC[i][4]) check($sformatf("vec%0d lvl R6", i), eoi_lvl, VEC[i][11:9]);
      if (i == 1) check("R4 vbase 0x75", vbase_q, 8'h70);
      if (i == 4) check("R2 mask", mask_q, 8'hA5);
    end

    check("R5 mask untouched by init words", mask_q, 8'hA5);
    check("R4 vbase last", vbase_q, 8'h48);
    do_rd(1'b1);
    check("R2 data read", rd_data, 8'hA5);

    // R3 restart in mid-sequence
    do_wr(1'b0, 8'h11);
    do_wr(1'b1, 8'hFF);
    check("R4 vbase mask", vbase_q, 8'hF8);
    check("R5 seq cascade", seq_idx, 2'd2);
    do_wr(1'b0, 8'h12);
    check("R3 restart", seq_idx, 2'd1);
    do_wr(1'b1, 8'h08);
    check("R5 back to idle", seq_idx, 2'd0);
    do_wr(1'b1, 8'h5A);
    check("R2 mask reload", mask_q, 8'h5A);

    // R9 read select
    do_rd(1'b0);
    check("R9 read irr", rd_data, 8'h3C);
    do_wr(1'b0, 8'h0B);
    check("R9 sel isr", sel_isr, 1'b1);
    do_rd(1'b0);
    check("R9 read isr", rd_data, 8'h81);
    do_wr(1'b0, 8'h09);
    check("R9 select kept", sel_isr, 1'b1);
    do_wr(1'b0, 8'h0A);
    isr_in = 8'h00;
    irr_in = 8'hC3;
    do_rd(1'b0);
    check("R9 read irr again", rd_data, 8'hC3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule